// File: doc/BRIEF.md
# Masked Exception Capture Register

This block holds the exception state of the processor-side interface of a memory bridge. Twelve exception classes come in as single-cycle event pulses. Each pulse sets a sticky status bit. Software reads the status word through a small register bus, and that read also clears the word. A second register, at a fixed offset above the status register, holds one enable bit per exception class.

The block combines status and enables into three level outputs. The first reports a processor-interface fault. The second reports a correctable ECC fault and the third an uncorrectable ECC fault. Interrupt logic elsewhere consumes these outputs. The ECC logic reports upper and lower data halves separately, and each pair of half-events is merged into one summary.

Both registers use descending bit numbering: exception number n occupies word position 31-n. Events are always captured into the status register, whatever the enable bits say. The enables gate only the summary outputs.

Top module: `exc_capture_top`

## Requirements
- R1: Exception number n appears at data-word position 31-n in both registers, and event input `evt_pulse[n]` drives exception number n.
- R2: A pulse on `evt_pulse[n]` sets status bit n at the next rising clock edge. The bit then stays set through any number of idle cycles until a status read.
- R3: A read of the status register (address `STAT_ADDR`, default 0x30060) returns the current status word in the same cycle through combinational `bus_rdata`. The edge that ends the read clears the status word.
- R4: An event that arrives in the same cycle as a clearing read is not returned by that read. It is still set after the read and appears on the following read.
- R5: Exception number 7 and word positions 0 to 19 are reserved in both registers. They always read 0, events on input 7 are ignored, and writes to them have no effect.
- R6: After reset the enable register reads 0xFEF00000, meaning every implemented exception is enabled. The status register reads 0 and all three summary outputs are 0.
- R7: The enable register sits at `STAT_ADDR + 0x10` (default 0x30070). It is read/write, and a written value is kept only at the implemented positions (mask 0xFEF00000).
- R8: `fault_cpu` is 1 exactly when some exception numbered 0 to 6 has both its status bit and its enable bit set.
- R9: `fault_ue` is 1 exactly when exception 8 or 10 is both set and enabled. `fault_ce` is 1 exactly when exception 9 or 11 is both set and enabled.
- R10: A cleared enable bit does not stop the matching status bit from being captured. Writes to the status register leave it unchanged.
- R11: A read of any other address returns 0 and leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (20) | Register byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no register is read |
| evt_pulse | input | 12 | Event pulses, index = exception number |
| fault_cpu | output | 1 | Processor-interface fault summary |
| fault_ce | output | 1 | Correctable ECC fault summary |
| fault_ue | output | 1 | Uncorrectable ECC fault summary |

## Verification
Read data is due in the cycle of the read strobe, so the bench samples `bus_rdata` one time unit after it drives the strobe on a falling edge, well before the clearing rising edge. Status bits and summary outputs change at the first rising edge after an event, a clearing read or an enable write. The bench checks them at the falling edge that follows, half a period later. The coincident-event case is checked over two reads: the first must omit the new event and the second must contain it. Sweeps cover every exception number, every single-bit enable hole, and all 4096 event combinations under a varying enable pattern.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int WORD_W  = 32;
   localparam int NUM_EXC = 12;

   // Exception sets, indexed by exception number
   localparam logic [NUM_EXC-1:0] IMPL_SET = 12'b1111_0111_1111;
   localparam logic [NUM_EXC-1:0] CPU_SET  = 12'b0000_0111_1111;
   localparam logic [NUM_EXC-1:0] UE_SET   = 12'b0101_0000_0000;
   localparam logic [NUM_EXC-1:0] CE_SET   = 12'b1010_0000_0000;

   // Place exception number n at word position WORD_W-1-n
   function automatic logic [WORD_W-1:0] to_word(input logic [NUM_EXC-1:0] v);
      logic [WORD_W-1:0] w;
      w = '0;
      for (int n = 0; n < NUM_EXC; n++) w[WORD_W-1-n] = v[n];
      return w;
   endfunction

   function automatic logic [NUM_EXC-1:0] from_word(input logic [WORD_W-1:0] w);
      logic [NUM_EXC-1:0] v;
      for (int n = 0; n < NUM_EXC; n++) v[n] = w[WORD_W-1-n];
      return v;
   endfunction

   localparam logic [WORD_W-1:0] IMPL_WORD = to_word(IMPL_SET);
   localparam logic [WORD_W-1:0] CPU_WORD  = to_word(CPU_SET);
   localparam logic [WORD_W-1:0] UE_WORD   = to_word(UE_SET);
   localparam logic [WORD_W-1:0] CE_WORD   = to_word(CE_SET);
endpackage

// File: rtl/exc_status_bank.sv
module exc_status_bank #(
   parameter int                   NUM  = 12,
   parameter logic [NUM-1:0]       IMPL = '1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] evt,
   input  logic           clr,
   output logic [NUM-1:0] stat
);
   for (genvar n = 0; n < NUM; n++) begin : g_bit
      if (IMPL[n]) begin : g_live
         // new event wins over a clearing read in the same cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stat[n] <= 1'b0;
            else        stat[n] <= evt[n] | (stat[n] & ~clr);
         end
      end else begin : g_rsvd
         logic unused_evt;
         assign unused_evt = evt[n];
         assign stat[n]    = 1'b0;
      end
   end
endmodule

// File: rtl/exc_mask_reg.sv
module exc_mask_reg #(
   parameter int             NUM  = 12,
   parameter logic [NUM-1:0] IMPL = '1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [NUM-1:0] wbits,
   output logic [NUM-1:0] mask
);
   for (genvar n = 0; n < NUM; n++) begin : g_bit
      if (IMPL[n]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  mask[n] <= 1'b1;
            else if (we) mask[n] <= wbits[n];
         end
      end else begin : g_rsvd
         logic unused_w;
         assign unused_w = wbits[n];
         assign mask[n]  = 1'b0;
      end
   end
endmodule

// File: rtl/exc_summary.sv
module exc_summary #(
   parameter int             NUM     = 12,
   parameter logic [NUM-1:0] CPU_SEL = '0,
   parameter logic [NUM-1:0] CE_SEL  = '0,
   parameter logic [NUM-1:0] UE_SEL  = '0
) (
   input  logic [NUM-1:0] stat,
   input  logic [NUM-1:0] mask,
   output logic           fault_cpu,
   output logic           fault_ce,
   output logic           fault_ue
);
   logic [NUM-1:0] live;
   assign live      = stat & mask;
   assign fault_cpu = |(live & CPU_SEL);
   assign fault_ce  = |(live & CE_SEL);
   assign fault_ue  = |(live & UE_SEL);
endmodule

// File: rtl/exc_capture_top.sv
module exc_capture_top
   import exc_pkg::*;
#(
   parameter int                ADDR_W    = 20,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 20'h30060,
   parameter logic [ADDR_W-1:0] MASK_OFS  = 20'h00010
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [WORD_W-1:0]   bus_wdata,
   output logic [WORD_W-1:0]   bus_rdata,
   input  logic [NUM_EXC-1:0]  evt_pulse,
   output logic                fault_cpu,
   output logic                fault_ce,
   output logic                fault_ue
);
   localparam logic [ADDR_W-1:0] MASK_ADDR = STAT_ADDR + MASK_OFS;

   if (NUM_EXC > WORD_W) begin : g_bad_width
      $error("exception count exceeds word width");
   end
   if (MASK_OFS == '0) begin : g_bad_ofs
      $error("enable register must not alias the status register");
   end

   logic                hit_stat, hit_mask;
   logic [NUM_EXC-1:0]  stat, mask, wbits;
   logic [WORD_W-1:0]   stat_word, mask_word;
   logic                unused_wdata;

   assign hit_stat = (bus_addr == STAT_ADDR);
   assign hit_mask = (bus_addr == MASK_ADDR);
   assign wbits    = from_word(bus_wdata);
   assign unused_wdata = ^bus_wdata[WORD_W-NUM_EXC-1:0];

   exc_status_bank #(.NUM(NUM_EXC), .IMPL(IMPL_SET)) u_stat (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (evt_pulse),
      .clr  (bus_rd & hit_stat),
      .stat (stat)
   );

   exc_mask_reg #(.NUM(NUM_EXC), .IMPL(IMPL_SET)) u_mask (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (bus_wr & hit_mask),
      .wbits(wbits),
      .mask (mask)
   );

   exc_summary #(.NUM(NUM_EXC), .CPU_SEL(CPU_SET), .CE_SEL(CE_SET), .UE_SEL(UE_SET)) u_sum (
      .stat     (stat),
      .mask     (mask),
      .fault_cpu(fault_cpu),
      .fault_ce (fault_ce),
      .fault_ue (fault_ue)
   );

   assign stat_word = to_word(stat);
   assign mask_word = to_word(mask);

   always_comb begin
      bus_rdata = '0;
      if (bus_rd && hit_stat)      bus_rdata = stat_word;
      else if (bus_rd && hit_mask) bus_rdata = mask_word;
   end
endmodule

// File: rtl/exc_capture_chk.sv
module exc_capture_chk
   import exc_pkg::*;
#(
   parameter int                ADDR_W    = 20,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 20'h30060,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 20'h30070
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_rd,
   input logic               bus_wr,
   input logic [NUM_EXC-1:0] evt_pulse,
   input logic               fault_cpu,
   input logic               fault_ce,
   input logic               fault_ue,
   input logic [WORD_W-1:0]  stat_word,
   input logic [WORD_W-1:0]  mask_word
);
   logic [WORD_W-1:0] evt_word;
   assign evt_word = to_word(evt_pulse) & IMPL_WORD;

   p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_word != 0) |=> ((stat_word & $past(evt_word)) == $past(evt_word)));

   p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == STAT_ADDR && evt_word == 0) |=> (stat_word == 0));

   p_event_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == STAT_ADDR && evt_word != 0) |=> (stat_word == $past(evt_word)));

   p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_word | mask_word) & ~IMPL_WORD) == 0);

   p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == MASK_ADDR) |=> $stable(mask_word));

   p_cpu_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_cpu |-> ((stat_word & mask_word & CPU_WORD) != 0));

   p_ue_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_ue |-> ((stat_word & mask_word & UE_WORD) != 0));

   p_ce_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_ce |-> ((stat_word & mask_word & CE_WORD) != 0));

   p_stat_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_rd && bus_addr == STAT_ADDR && evt_word == 0) |=> $stable(stat_word));
endmodule

bind exc_capture_top exc_capture_chk #(
   .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
   .evt_pulse(evt_pulse), .fault_cpu(fault_cpu), .fault_ce(fault_ce), .fault_ue(fault_ue),
   .stat_word(stat_word), .mask_word(mask_word)
);

// File: tb/exc_capture_top_test.sv
module exc_capture_top_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [19:0] A_STAT = 20'h30060;
   localparam logic [19:0] A_MASK = 20'h30070;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [11:0] evt_pulse = '0;
   logic        fault_cpu, fault_ce, fault_ue;

   int checks = 0;
   int errors = 0;

   exc_capture_top uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
      .fault_cpu(fault_cpu), .fault_ce(fault_ce), .fault_ue(fault_ue)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // expected word: exception n at position 31-n, number 7 reserved
   function automatic logic [31:0] exp_word(input logic [11:0] v);
      logic [31:0] w = '0;
      for (int n = 0; n < 12; n++) if (n != 7) w[31-n] = v[n];
      return w;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic chk_faults(input string req, input logic [11:0] st, input logic [11:0] mk);
      logic [11:0] l;
      l = st & mk & 12'b1111_0111_1111;
      chk({req, " fault_cpu"}, {31'd0, fault_cpu}, {31'd0, |l[6:0]});
      chk({req, " fault_ue"},  {31'd0, fault_ue},  {31'd0, l[8] | l[10]});
      chk({req, " fault_ce"},  {31'd0, fault_ce},  {31'd0, l[9] | l[11]});
   endtask

   task automatic rd(input logic [19:0] a, input logic [11:0] ev, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; evt_pulse = ev;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; evt_pulse = '0;
   endtask

   task automatic wr(input logic [19:0] a, input logic [31:0] v);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = v;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic pulse(input logic [11:0] ev);
      @(negedge clk);
      evt_pulse = ev;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [11:0] mk;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R6: reset state
      chk_faults("R6 reset", 12'h000, 12'hFFF);
      rd(A_MASK, '0, d); chk("R6 mask reset", d, 32'hFEF00000);
      rd(A_STAT, '0, d); chk("R6 status reset", d, 32'h0);

      // R1 R2 R3 R5 R8 R9: every exception number alone
      for (int n = 0; n < 12; n++) begin
         pulse(12'(1 << n));
         repeat (2) @(negedge clk);
         chk_faults("R8/R9 single", 12'(1 << n), 12'hFFF);
         rd(A_STAT, '0, d); chk("R1 R2 R5 single read", d, exp_word(12'(1 << n)));
         chk_faults("R3 after clear", 12'h000, 12'hFFF);
         rd(A_STAT, '0, d); chk("R3 second read", d, 32'h0);
      end

      // R2: separate pulses accumulate
      pulse(12'h001); repeat (4) @(negedge clk); pulse(12'h200);
      rd(A_STAT, '0, d); chk("R2 sticky accumulate", d, exp_word(12'h201));

      // R7 R5: enable register write/read
      wr(A_MASK, 32'hFFFFFFFF); rd(A_MASK, '0, d); chk("R7 R5 mask all ones", d, 32'hFEF00000);
      wr(A_MASK, 32'h0);        rd(A_MASK, '0, d); chk("R7 mask zero", d, 32'h0);

      // R10 R8 R9: one enable hole per exception
      for (int n = 0; n < 12; n++) begin
         mk = ~12'(1 << n);
         wr(A_MASK, exp_word(mk));
         pulse(12'(1 << n));
         chk_faults("R10 masked", 12'(1 << n), mk);
         rd(A_STAT, '0, d); chk("R10 captured while masked", d, exp_word(12'(1 << n)));
      end
      wr(A_MASK, 32'hFFFFFFFF);

      // R10: status writes ignored
      pulse(12'h010);
      wr(A_STAT, 32'hFFFFFFFF); wr(A_STAT, 32'h0);
      rd(A_STAT, '0, d); chk("R10 status write ignored", d, exp_word(12'h010));
      wr(A_STAT, 32'hFFFFFFFF);
      rd(A_STAT, '0, d); chk("R10 status write sets nothing", d, 32'h0);

      // R4: event during clearing read
      pulse(12'h004);
      rd(A_STAT, 12'h024, d); chk("R4 coincident read", d, exp_word(12'h004));
      chk_faults("R4 kept fault", 12'h024, 12'hFFF);
      rd(A_STAT, '0, d); chk("R4 kept event", d, exp_word(12'h024));

      // R11: other address
      pulse(12'h100);
      rd(20'h30064, '0, d); chk("R11 other address", d, 32'h0);
      rd(20'h00000, '0, d); chk("R11 address zero", d, 32'h0);
      rd(A_STAT, '0, d); chk("R11 status intact", d, exp_word(12'h100));

      // R8 R9 R2: all event combinations with a varying enable pattern
      for (int k = 0; k < 4096; k++) begin
         mk = 12'((k * 7 + 3) ^ (k >> 3));
         if (k % 256 == 0) wr(A_MASK, exp_word(mk));
         else mk = 12'(((k & ~255) * 7 + 3) ^ ((k & ~255) >> 3));
         pulse(12'(k));
         chk_faults("R8/R9 sweep", 12'(k), mk);
         rd(A_STAT, '0, d); chk("R2 sweep read", d, exp_word(12'(k)));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule